// File: doc/BRIEF.md
# Programmable Interval Timer with Capture and Compare

This block is a 16-bit timer peripheral that sits on a simple register bus. A clock source is chosen among the bus clock, the bus clock divided by 16, a synchronized external clock pin, or nothing at all. That source is divided by an 8-bit prescaler, and each prescaler terminal tick advances an up-counter. When the counter reaches the programmed compare value, the block sets a compare flag and drives its timer output, either as a one-cycle low pulse or as a toggle. Depending on the mode, the counter then either drops back to zero or keeps running and wraps.

A capture input passes through a synchronizer. On the selected edge, the current count is latched into a capture register and a capture flag is set. Both flags are cleared by writing one to them. Each flag has its own enable onto the single interrupt line. Software programs the block through five registers: the mode at offset 0x00, the compare value at 0x04, the capture value at 0x08 (read only), the counter at 0x0C, and the byte-wide flag register at 0x11.

Top module: `gp_timer`

## Requirements
- R1: After reset the mode reads 0x0000, compare 0xFFFF, capture 0x0000, counter 0x0000 and flags 0x0000. The timer output is high and the interrupt is low.
- R2: While mode bit 0 (enable) is 0, the counter, prescaler, flags and output are held at their idle values (count 0, flags 0, output high) starting one cycle after the enable bit is cleared.
- R3: A prescale value N in mode bits 15:8 advances the counter once per N+1 source ticks. With the bus clock selected, the count k clock edges after enabling is floor(k/(N+1)), taken modulo the restart period.
- R4: Mode bits 2:1 pick the source. 00 stops the count, 01 uses every bus clock, 10 uses every 16th bus clock, and 11 uses rising edges of the external clock pin after a two-flop synchronizer.
- R5: Any write to offset 0x0C clears the counter and the prescaler phase on that edge, whatever the data.
- R6: With mode bit 3 (restart) set, the counter runs 0 up to the compare value and then returns to 0, giving a period of compare+1 counts.
- R7: With restart clear, the counter continues past the compare value and wraps from 0xFFFF to 0x0000.
- R8: The compare flag (flag bit 1) is set on the edge where the counter becomes equal to the compare value. It raises the interrupt only when mode bit 4 is 1.
- R9: With mode bit 5 at 0, the timer output goes low for exactly the one cycle that follows each compare match.
- R10: With mode bit 5 at 1, the timer output inverts on each compare match, starting from high.
- R11: Mode bits 7:6 choose the capture edge: 00 none, 01 rising, 10 falling, 11 both. On that edge, three clocks after the input changes, the count is copied into the capture register and flag bit 0 is set. Otherwise the capture register is unchanged.
- R12: The capture flag raises the interrupt whenever mode bits 7:6 are nonzero. Writes to the capture offset have no effect.
- R13: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. Flag register bits 15:2 read as zero. A new event in the same cycle as a clearing write leaves the flag set.
- R14: The mode and compare registers read back what was written, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| ext_clk | input | 1 | External count source, asynchronous |
| cap_in | input | 1 | Capture trigger, asynchronous |
| tmr_out | output | 1 | Timer output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the compare register is not rewritten on the same edge as a match, and that the capture and external clock inputs hold each level for at least three bus clocks, so that the synchronizers never miss an edge. The stimulus meets both conditions: it changes the compare value only while the timer is disabled, and it holds every pin level for three or more cycles. The sweeps cover each prescale and compare pair in a small range, every edge-mode and direction pair, and a full wrap of the counter.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the timer: bus geometry, register
// offsets and the mode register layout. Assumes a 16-bit data bus.
package gpt_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;
    localparam int PS_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h11;

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_BUS = 2'b01,
        SRC_DIV = 2'b10,
        SRC_EXT = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    // Mode register, most significant field first (bits 15..0).
    typedef struct packed {
        logic [PS_W-1:0] psc;
        edge_e           cap_edge;
        logic            out_toggle;
        logic            cmp_irq_en;
        logic            restart;
        src_e            src;
        logic            enable;
    } mode_t;
endpackage

// File: rtl/gpt_regs.sv
`timescale 1ns/1ps
// Register file and bus decode. Holds the mode, compare and flag
// registers, produces the counter-clear strobe and the read mux.
// Assumes CNT_W <= BUS_W; reads are combinational on addr.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  cap_val,
    input  logic              cmp_fire,
    input  logic              cap_fire,
    output mode_t             mode_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [1:0]        flags_q,
    output logic              cnt_clr,
    output logic [BUS_W-1:0]  rdata
);
    logic       wr_mode;
    logic       wr_cmp;
    logic       wr_flag;
    logic [1:0] clr_mask;

    // Decode write strobes per register.
    always_comb begin
        wr_mode  = wr_en && (addr == OFS_MODE);
        wr_cmp   = wr_en && (addr == OFS_CMP);
        wr_flag  = wr_en && (addr == OFS_FLAG);
        cnt_clr  = wr_en && (addr == OFS_CNT);
        clr_mask = wr_flag ? wdata[1:0] : 2'b00;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= mode_t'(wdata);
    end

    // Compare register, resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
    end

    // Event flags: write-one-to-clear, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)              flags_q <= 2'b00;
        else if (!mode_q.enable) flags_q <= 2'b00;
        else                     flags_q <= (flags_q & ~clr_mask) | {cmp_fire, cap_fire};
    end

    // Read mux, unmapped offsets return zero.
    always_comb begin
        unique case (addr)
            OFS_MODE: rdata = mode_q;
            OFS_CMP:  rdata = BUS_W'(cmp_q);
            OFS_CAP:  rdata = BUS_W'(cap_val);
            OFS_CNT:  rdata = BUS_W'(cnt_val);
            OFS_FLAG: rdata = {{(BUS_W-2){1'b0}}, flags_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpt_tick.sv
`timescale 1ns/1ps
// Count-tick generator: selects the source (off, bus clock, bus clock
// divided by 2**DIV_LOG2, synchronized external rising edge) and runs
// the prescaler. Assumes ext_clk levels last at least SYNC_STAGES+1
// clocks. All phase state is cleared while disabled or on cnt_clr.
module gpt_tick
    import gpt_pkg::*;
#(
    parameter int DIV_LOG2    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cnt_clr,
    input  src_e            src,
    input  logic [PS_W-1:0] psc_lim,
    input  logic            ext_clk,
    output logic            cnt_tick
);
    logic [SYNC_STAGES:0] ext_sr;
    logic                 ext_rise;
    logic                 div_tick;
    logic                 src_tick;
    logic [PS_W-1:0]      psc_q;

    // External clock synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sr <= '0;
        else        ext_sr <= {ext_sr[SYNC_STAGES-1:0], ext_clk};
    end

    assign ext_rise = ext_sr[SYNC_STAGES-1] & ~ext_sr[SYNC_STAGES];

    generate
        if (DIV_LOG2 > 0) begin : g_div
            logic [DIV_LOG2-1:0] div_q;
            // Free-running fixed divider, phase cleared with the counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                 div_q <= '0;
                else if (!enable || cnt_clr) div_q <= '0;
                else                        div_q <= div_q + 1'b1;
            end
            assign div_tick = &div_q;
        end else begin : g_nodiv
            assign div_tick = 1'b1;
        end
    endgenerate

    // Source selection.
    always_comb begin
        unique case (src)
            SRC_OFF: src_tick = 1'b0;
            SRC_BUS: src_tick = 1'b1;
            SRC_DIV: src_tick = div_tick;
            SRC_EXT: src_tick = ext_rise;
            default: src_tick = 1'b0;
        endcase
    end

    assign cnt_tick = enable && !cnt_clr && src_tick && (psc_q == psc_lim);

    // Prescaler: counts source ticks 0..psc_lim.
    always_ff @(posedge clk) begin
        if (!rst_n)                  psc_q <= '0;
        else if (!enable || cnt_clr) psc_q <= '0;
        else if (src_tick)           psc_q <= (psc_q == psc_lim) ? '0 : psc_q + 1'b1;
    end
endmodule

// File: rtl/gpt_count.sv
`timescale 1ns/1ps
// Up-counter with compare, optional restart and the timer output.
// Assumes cnt_tick is already gated by enable; a counter write
// suppresses any match on the same edge.
module gpt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             out_toggle,
    input  logic             cnt_clr,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cmp_fire,
    output logic             tmr_out
);
    logic [CNT_W-1:0] cnt_nxt;

    // Next count and match detection.
    always_comb begin
        cnt_nxt  = (restart && (cnt_q == cmp_val)) ? '0 : cnt_q + 1'b1;
        cmp_fire = enable && cnt_tick && !cnt_clr && (cnt_nxt == cmp_val);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!enable || cnt_clr) cnt_q <= '0;
        else if (cnt_tick)           cnt_q <= cnt_nxt;
    end

    // Output: one-cycle low pulse or toggle on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)          tmr_out <= 1'b1;
        else if (!enable)    tmr_out <= 1'b1;
        else if (cmp_fire)   tmr_out <= out_toggle ? ~tmr_out : 1'b0;
        else if (!out_toggle) tmr_out <= 1'b1;
    end
endmodule

// File: rtl/gpt_capture.sv
`timescale 1ns/1ps
// Capture path: synchronizes cap_in, detects the selected edge and
// latches the count. Assumes cap_in levels last at least
// SYNC_STAGES+1 clocks. The capture register keeps its value while
// the timer is disabled.
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  edge_e            cap_edge,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_fire
);
    logic [SYNC_STAGES:0] cap_sr;
    logic                 rise;
    logic                 fall;
    logic                 hit;

    // Synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_sr <= '0;
        else        cap_sr <= {cap_sr[SYNC_STAGES-1:0], cap_in};
    end

    // Edge selection.
    always_comb begin
        rise = cap_sr[SYNC_STAGES-1] & ~cap_sr[SYNC_STAGES];
        fall = ~cap_sr[SYNC_STAGES-1] & cap_sr[SYNC_STAGES];
        unique case (cap_edge)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        cap_fire = enable && hit;
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_fire) cap_q <= cnt_val;
    end
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
// Timer top: wires the register file, tick generator, counter and
// capture path, and forms the interrupt from flags and enables.
// Assumes a single synchronous clock domain for the bus.
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_LOG2    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              ext_clk,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [1:0]       flags_q;
    logic             cnt_clr;
    logic             cnt_tick;
    logic             cmp_fire;
    logic             cap_fire;
    logic             tmr_en;
    logic [1:0]       cap_mode;

    assign tmr_en   = mode_q.enable;
    assign cap_mode = mode_q.cap_edge;

    gpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_val(cnt_q), .cap_val(cap_q), .cmp_fire(cmp_fire), .cap_fire(cap_fire),
        .mode_q(mode_q), .cmp_q(cmp_q), .flags_q(flags_q), .cnt_clr(cnt_clr),
        .rdata(rdata)
    );

    gpt_tick #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .enable(tmr_en), .cnt_clr(cnt_clr),
        .src(mode_q.src), .psc_lim(mode_q.psc), .ext_clk(ext_clk),
        .cnt_tick(cnt_tick)
    );

    gpt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .enable(tmr_en), .restart(mode_q.restart),
        .out_toggle(mode_q.out_toggle), .cnt_clr(cnt_clr), .cnt_tick(cnt_tick),
        .cmp_val(cmp_q), .cnt_q(cnt_q), .cmp_fire(cmp_fire), .tmr_out(tmr_out)
    );

    gpt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .enable(tmr_en), .cap_edge(mode_q.cap_edge),
        .cap_in(cap_in), .cnt_val(cnt_q), .cap_q(cap_q), .cap_fire(cap_fire)
    );

    // Interrupt request from enabled flags.
    always_comb begin
        irq = (flags_q[1] & mode_q.cmp_irq_en) | (flags_q[0] & (cap_mode != 2'b00));
    end
endmodule

// File: rtl/gpt_checker.sv
`timescale 1ns/1ps
// Temporal checks on the timer, attached to gp_timer by bind.
// Assumes the compare value is not rewritten on a matching edge.
module gpt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cap_fire,
    input logic             tmr_out,
    input logic [1:0]       flags_q,
    input logic [1:0]       cap_edge,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q
);
    // R2: a disabled timer is idle on the next cycle.
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt_q == '0 && flags_q == 2'b00 && tmr_out));

    // R6: the counter only holds, steps by one or returns to zero.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));

    // R8: the compare flag rises only when the count reached the compare value.
    a_r8_flag_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[1]) |-> (cnt_q == $past(cmp_q)));

    // R9: the output only falls on a compare match.
    a_r9_out_falls_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_out) |-> flags_q[1]);

    // R11: the capture flag rises only after a selected edge.
    a_r11_cap_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[0]) |-> ($past(cap_fire) && $past(cap_edge) != 2'b00));

    // R13: a capture event always leaves the flag set.
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && enable) |=> flags_q[0]);
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(tmr_en), .cap_fire(cap_fire),
    .tmr_out(tmr_out), .flags_q(flags_q), .cap_edge(cap_mode),
    .cnt_q(cnt_q), .cmp_q(cmp_q)
);

// File: tb/gp_timer_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps prescale/compare pairs, sources, output
// modes, capture edges and flag clearing; expected values are computed.
module gp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic        tmr_out;
    logic        irq;
    int          vectors = 0;
    int          fails = 0;

    localparam logic [4:0] A_MODE = 5'h00, A_CMP = 5'h04, A_CAP = 5'h08,
                           A_CNT = 5'h0C, A_FLAG = 5'h11;

    gp_timer u_gp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .tmr_out(tmr_out),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] mk(input int ps, input int edg, input bit tog,
                                       input bit ori, input bit rs, input int src,
                                       input bit en);
        return {ps[7:0], edg[1:0], tog, ori, rs, src[1:0], en};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        addr = a; #0.5;
        d = rdata;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual running expected done");
        report();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp_cap;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 reset values
        rd(A_MODE, v); chk("R1 mode", v, 16'h0000);
        rd(A_CMP, v);  chk("R1 cmp", v, 16'hFFFF);
        rd(A_CAP, v);  chk("R1 cap", v, 16'h0000);
        rd(A_CNT, v);  chk("R1 cnt", v, 16'h0000);
        rd(A_FLAG, v); chk("R1 flag", v, 16'h0000);
        chk("R1 out", {15'd0, tmr_out}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R14 register map, R12 capture offset read only
        wr(A_MODE, 16'hFF0C); rd(A_MODE, v); chk("R14 mode readback", v, 16'hFF0C);
        wr(A_CMP, 16'hAFAF);  rd(A_CMP, v);  chk("R14 cmp readback", v, 16'hAFAF);
        wr(A_CAP, 16'h1234);  rd(A_CAP, v);  chk("R12 cap not writable", v, 16'h0000);
        rd(5'h14, v); chk("R14 unmapped", v, 16'h0000);

        // R3 R6 R8 R9 sweep of prescale and compare with restart
        for (int ps = 0; ps < 4; ps++) begin
            for (int r = 1; r < 5; r++) begin
                wr(A_MODE, 16'h0000);
                wr(A_CMP, 16'(r));
                wr(A_MODE, mk(ps, 0, 0, 1, 1, 1, 1));
                for (int k = 1; k <= 3 * (ps + 1) * (r + 1); k++) begin
                    int c;
                    bit f;
                    bit lo;
                    @(posedge clk); #1;
                    c  = (k / (ps + 1)) % (r + 1);
                    f  = (k >= r * (ps + 1));
                    lo = (k % (ps + 1) == 0) && (c == r);
                    rd(A_CNT, v);  chk("R3 R6 count", v, 16'(c));
                    rd(A_FLAG, v); chk("R8 cmp flag", v, f ? 16'h0002 : 16'h0000);
                    chk("R8 irq", {15'd0, irq}, {15'd0, f});
                    chk("R9 pulse", {15'd0, tmr_out}, {15'd0, !lo});
                end
            end
        end

        // R10 toggle output, compare 2 with restart
        wr(A_MODE, 16'h0000); wr(A_CMP, 16'd2);
        wr(A_MODE, mk(0, 0, 1, 0, 1, 1, 1));
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); #1;
            chk("R10 toggle", {15'd0, tmr_out}, {15'd0, (((k + 1) / 3) % 2) == 0});
        end

        // R4 divide-by-16 source, compare flag without irq enable (R8)
        wr(A_MODE, 16'h0000); wr(A_CMP, 16'hFFFF);
        wr(A_MODE, mk(0, 0, 0, 0, 0, 2, 1));
        for (int k = 1; k <= 70; k++) begin
            @(posedge clk); #1;
            rd(A_CNT, v); chk("R4 div16", v, 16'(k / 16));
        end
        // R4 source off
        wr(A_MODE, 16'h0000);
        wr(A_MODE, mk(0, 0, 0, 0, 0, 0, 1));
        repeat (20) @(posedge clk); #1;
        rd(A_CNT, v); chk("R4 off", v, 16'h0000);
        // R4 external source with prescale 1
        wr(A_MODE, 16'h0000);
        wr(A_MODE, mk(1, 0, 0, 0, 0, 3, 1));
        for (int p = 0; p < 6; p++) begin
            ext_clk = 1'b1; repeat (3) @(posedge clk); #1;
            ext_clk = 1'b0; repeat (3) @(posedge clk); #1;
        end
        repeat (4) @(posedge clk); #1;
        rd(A_CNT, v); chk("R4 ext", v, 16'd3);

        // R5 counter write clears count and prescaler phase
        wr(A_MODE, 16'h0000); wr(A_CMP, 16'hFFFF);
        wr(A_MODE, mk(2, 0, 0, 0, 0, 1, 1));
        repeat (10) @(posedge clk); #1;
        rd(A_CNT, v); chk("R5 before", v, 16'd3);
        wr(A_CNT, 16'hABCD);
        rd(A_CNT, v); chk("R5 cleared", v, 16'd0);
        for (int m = 1; m <= 9; m++) begin
            @(posedge clk); #1;
            rd(A_CNT, v); chk("R5 phase", v, 16'(m / 3));
        end

        // R7 free run past compare and wrap
        wr(A_MODE, 16'h0000); wr(A_CMP, 16'd2);
        wr(A_MODE, mk(0, 0, 0, 1, 0, 1, 1));
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #1;
            rd(A_CNT, v);  chk("R7 run", v, 16'(k));
            rd(A_FLAG, v); chk("R7 flag", v, (k >= 2) ? 16'h0002 : 16'h0000);
        end
        repeat (65535 - 6) @(posedge clk); #1;
        rd(A_CNT, v); chk("R7 top", v, 16'hFFFF);
        @(posedge clk); #1;
        rd(A_CNT, v); chk("R7 wrap", v, 16'h0000);

        // R2 disable holds everything idle
        wr(A_MODE, mk(0, 0, 0, 1, 0, 1, 0));
        @(posedge clk); #1;
        rd(A_CNT, v);  chk("R2 cnt", v, 16'h0000);
        rd(A_FLAG, v); chk("R2 flag", v, 16'h0000);
        chk("R2 out", {15'd0, tmr_out}, 16'd1);
        chk("R2 irq", {15'd0, irq}, 16'd0);
        repeat (10) @(posedge clk); #1;
        rd(A_CNT, v); chk("R2 held", v, 16'h0000);

        // R13 write-one-to-clear, set wins, reserved bits
        wr(A_MODE, 16'h0000); wr(A_CMP, 16'd3);
        wr(A_MODE, mk(0, 0, 0, 0, 1, 1, 1));
        repeat (4) @(posedge clk); #1;
        rd(A_FLAG, v); chk("R13 set", v, 16'h0002);
        chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);
        wr(A_FLAG, 16'h0000); rd(A_FLAG, v); chk("R13 write zero", v, 16'h0002);
        wr(A_FLAG, 16'h0002); rd(A_FLAG, v); chk("R13 clear", v, 16'h0000);
        wr(A_FLAG, 16'h0002); rd(A_FLAG, v); chk("R13 set wins", v, 16'h0002);
        wr(A_FLAG, 16'hFFFF); rd(A_FLAG, v); chk("R13 reserved", v, 16'h0000);

        // R11 R12 capture edge sweep on a frozen count
        exp_cap = 16'h0000;
        for (int e = 0; e < 4; e++) begin
            for (int d = 0; d < 2; d++) begin
                int t;
                bit hit;
                t = 3 + e * 2 + d;
                wr(A_MODE, 16'h0000); wr(A_CMP, 16'hFFFF);
                wr(A_MODE, mk(0, e, 0, 0, 0, 1, 1));
                repeat (t) @(posedge clk); #1;
                wr(A_MODE, mk(0, e, 0, 0, 0, 0, 1));
                rd(A_CNT, v); chk("R4 frozen", v, 16'(t + 1));
                cap_in = (d == 0);
                repeat (4) @(posedge clk); #1;
                hit = (e == 3) || (e == 1 && d == 0) || (e == 2 && d == 1);
                if (hit) exp_cap = 16'(t + 1);
                rd(A_CAP, v);  chk("R11 cap value", v, exp_cap);
                rd(A_FLAG, v); chk("R11 cap flag", v, {15'd0, hit});
                chk("R12 cap irq", {15'd0, irq}, {15'd0, hit});
            end
        end

        report();
    end
endmodule